// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block produces the bus-level control strobes of a NAND flash interface for one byte transfer at a time. A requester hands it a single read or write over a valid/ready request channel. The block drives chip enable low and waits out an access delay. For a read that directly follows a write it also inserts a bus turnaround gap. It then drives the read or write strobe low and high for programmed cycle counts, and finally returns a completion, carrying the sampled byte on reads, over a valid/ready response channel. Command and address latching, error correction and page buffering belong to neighbouring blocks.

All phase lengths come from one packed timing word. That word can only be changed by an unlock pulse followed by a write. The block also watches the device ready/busy line through a synchronizer and reports the device ready only after a programmable settle delay has elapsed since the line went high. Requests are taken only while the device is ready and the block is idle. The response is held until the requester takes it (back-pressure), and no new request is accepted while a response is pending.

Top module: `nand_strobe_timer`

## Requirements
- R1: The timing word is laid out, from bit 0 upward, as write-low count [3:0], write-high count [7:4], read-low count [11:8], read-high count [15:12], turnaround count [18:16], busy-settle count [23:19] and chip-enable access count [25:24]; each count is in clock cycles.
- R2: A timing word write takes effect only if an unlock pulse has been seen since the previous timing write; every write, applied or not, consumes the unlock, and a write without a pending unlock leaves `cfg_timing` unchanged.
- R3: A count field holding 0 behaves exactly like a field holding 1.
- R4: `nand_ce_n` is low for the whole bus cycle, and both strobes stay high for the access count of cycles after it falls before any strobe goes low.
- R5: A read holds `nand_re_n` low for the read-low count, then high for the read-high count; the byte on `nand_dq_in` in the last low cycle is the one returned.
- R6: A write holds `nand_we_n` low for the write-low count, then high for the write-high count, and drives `nand_dq_out` with the request byte and `nand_dq_oe` high through both phases.
- R7: The turnaround count of idle cycles is inserted after the access delay only when a read directly follows a write; after that read, and for a write or a read after a read, no gap is added.
- R8: `dev_ready` drops when the synchronized ready/busy line is low and rises exactly (2 + busy-settle count) cycles after `nand_rb` goes high; requests are not accepted while `dev_ready` is low.
- R9: `rsp_valid` rises when the strobe high phase ends and stays high with `rsp_rdata` stable until `rsp_ready`; while it is high `req_ready` is low; for a write the returned byte is 0.
- R10: `nand_re_n` and `nand_we_n` are never low together, and neither is low while `nand_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_unlock | input | 1 | Pulse that permits the next timing write |
| cfg_wr | input | 1 | Timing word write strobe |
| cfg_wdata | input | 26 | Timing word to write |
| cfg_timing | output | 26 | Current timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and device ready; request taken when both high |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Completion present |
| rsp_ready | input | 1 | Requester takes the completion |
| rsp_rdata | output | 8 | Byte read (0 after a write) |
| dev_ready | output | 1 | Device ready after busy settle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq_out | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data returned by the flash |
| nand_rb | input | 1 | Ready/busy line, high = ready |

## Verification
Every cycle, the assertions check the structural rules. The strobes are never low together or outside chip enable. The data bus is only enabled with the read strobe high. A held response keeps its byte, and no request is taken while the device is unready or a response is pending. A settling ready line never reports ready in its first cycle, and a locked timing write never moves the register. Only the bench scenarios can show the exact phase lengths for each field value, including zero fields. They also show when the turnaround gap appears, which byte of a changing data bus is captured, and the exact ready rise delay for different settle counts.

// File: rtl/nst_pkg.sv
package nst_pkg;

  // Packed timing word width and widest count field.
  localparam int TW = 26;
  localparam int CW = 5;

  // Field order follows bit position, most significant first.
  typedef struct packed {
    logic [1:0] cea;   // chip enable to access
    logic [4:0] bsy;   // settle after ready/busy rises
    logic [2:0] ta;    // turnaround, read after write
    logic [3:0] rh;    // read strobe high
    logic [3:0] rl;    // read strobe low
    logic [3:0] wh;    // write strobe high
    logic [3:0] wl;    // write strobe low
  } nst_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_TURN,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } nst_state_e;

  // A zero count still spends one cycle.
  function automatic logic [CW-1:0] nst_min1(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

endpackage

// File: rtl/nst_cfg_reg.sv
module nst_cfg_reg
  import nst_pkg::*;
#(
  parameter logic [TW-1:0] RST_TIMING = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlock_i,
  input  logic          wr_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] timing_o,
  output logic          armed_o
);

  logic [TW-1:0] timing_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_q <= RST_TIMING;
      armed_q  <= 1'b0;
    end else if (wr_i) begin
      if (armed_q) timing_q <= wdata_i;
      // any write consumes the permission; a same-cycle unlock re-arms
      armed_q <= unlock_i;
    end else if (unlock_i) begin
      armed_q <= 1'b1;
    end
  end

  assign timing_o = timing_q;
  assign armed_o  = armed_q;

endmodule

// File: rtl/nst_ready_mon.sv
module nst_ready_mon
  import nst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rb_i,
  input  logic [CW-1:0] settle_i,
  output logic          rb_sync_o,
  output logic          ready_o
);

  logic          rb_s;
  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-2:0], rb_i};
      end
      assign rb_s = sh_q[SYNC_STAGES-1];
    end else begin : g_single
      logic s_q;
      always_ff @(posedge clk) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= rb_i;
      end
      assign rb_s = s_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rb_s) begin
      cnt_q <= nst_min1(settle_i);
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q > CW'(1)) cnt_q <= cnt_q - CW'(1);
      else                rdy_q <= 1'b1;
    end
  end

  assign rb_sync_o = rb_s;
  assign ready_o   = rdy_q & rb_s;

endmodule

// File: rtl/nst_phase_seq.sv
module nst_phase_seq
  import nst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cea_i,
  input  logic [CW-1:0] ta_i,
  input  logic [CW-1:0] rl_i,
  input  logic [CW-1:0] rh_i,
  input  logic [CW-1:0] wl_i,
  input  logic [CW-1:0] wh_i,
  input  logic          dev_ready_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          ce_n_o,
  output logic          re_n_o,
  output logic          we_n_o,
  output logic [DW-1:0] dq_out_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_in_i
);

  nst_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          op_wr_q;
  logic          last_wr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q;
  logic          last_cyc;
  logic          accept;

  assign last_cyc = (cnt_q == CW'(1));
  assign accept   = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      op_wr_q   <= 1'b0;
      last_wr_q <= 1'b0;
      wdat_q    <= '0;
      rdat_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_ACC;
          cnt_q   <= nst_min1(cea_i);
          op_wr_q <= req_write_i;
          wdat_q  <= req_wdata_i;
        end
        ST_ACC: if (last_cyc) begin
          if (!op_wr_q && last_wr_q) begin
            st_q  <= ST_TURN;
            cnt_q <= nst_min1(ta_i);
          end else begin
            st_q  <= ST_LOW;
            cnt_q <= nst_min1(op_wr_q ? wl_i : rl_i);
          end
        end else cnt_q <= cnt_q - CW'(1);
        ST_TURN: if (last_cyc) begin
          st_q  <= ST_LOW;
          cnt_q <= nst_min1(rl_i);
        end else cnt_q <= cnt_q - CW'(1);
        ST_LOW: if (last_cyc) begin
          st_q   <= ST_HIGH;
          cnt_q  <= nst_min1(op_wr_q ? wh_i : rh_i);
          rdat_q <= op_wr_q ? '0 : dq_in_i;
        end else cnt_q <= cnt_q - CW'(1);
        ST_HIGH: if (last_cyc) begin
          st_q      <= ST_DONE;
          last_wr_q <= op_wr_q;
        end else cnt_q <= cnt_q - CW'(1);
        ST_DONE: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE) && dev_ready_i;
  assign rsp_valid_o = (st_q == ST_DONE);
  assign rsp_rdata_o = rdat_q;
  assign ce_n_o      = !((st_q == ST_ACC) || (st_q == ST_TURN) ||
                         (st_q == ST_LOW) || (st_q == ST_HIGH));
  assign re_n_o      = !((st_q == ST_LOW) && !op_wr_q);
  assign we_n_o      = !((st_q == ST_LOW) && op_wr_q);
  assign dq_oe_o     = op_wr_q && ((st_q == ST_LOW) || (st_q == ST_HIGH));
  assign dq_out_o    = dq_oe_o ? wdat_q : '0;

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nst_pkg::*;
#(
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [TW-1:0] RST_TIMING  = {2'd1, 5'd2, 3'd1, 4'd2, 4'd2, 4'd2, 4'd2}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_unlock,
  input  logic          cfg_wr,
  input  logic [TW-1:0] cfg_wdata,
  output logic [TW-1:0] cfg_timing,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          dev_ready,
  output logic          nand_ce_n,
  output logic          nand_re_n,
  output logic          nand_we_n,
  output logic [DW-1:0] nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_in,
  input  logic          nand_rb
);

  nst_timing_t tq;
  logic        cfg_armed;
  logic        rb_sync;

  nst_cfg_reg #(.RST_TIMING(RST_TIMING)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlock_i (cfg_unlock),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .timing_o (cfg_timing),
    .armed_o  (cfg_armed)
  );

  assign tq = nst_timing_t'(cfg_timing);

  nst_ready_mon #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_i      (nand_rb),
    .settle_i  (CW'(tq.bsy)),
    .rb_sync_o (rb_sync),
    .ready_o   (dev_ready)
  );

  nst_phase_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cea_i       (CW'(tq.cea)),
    .ta_i        (CW'(tq.ta)),
    .rl_i        (CW'(tq.rl)),
    .rh_i        (CW'(tq.rh)),
    .wl_i        (CW'(tq.wl)),
    .wh_i        (CW'(tq.wh)),
    .dev_ready_i (dev_ready),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_ready_i (rsp_ready),
    .rsp_rdata_o (rsp_rdata),
    .ce_n_o      (nand_ce_n),
    .re_n_o      (nand_re_n),
    .we_n_o      (nand_we_n),
    .dq_out_o    (nand_dq_out),
    .dq_oe_o     (nand_dq_oe),
    .dq_in_i     (nand_dq_in)
  );

endmodule

// File: rtl/nst_checker.sv
module nst_checker
  import nst_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_armed,
  input logic [TW-1:0] cfg_timing,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          dev_ready,
  input logic          rb_sync,
  input logic          nand_ce_n,
  input logic          nand_re_n,
  input logic          nand_we_n,
  input logic          nand_dq_oe
);

  // R2: a write with no pending unlock leaves the timing word alone
  a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_armed) |=> $stable(cfg_timing));

  // R4: the first chip-enable cycle is part of the access delay
  a_r4_access_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_ce_n) |-> (nand_re_n && nand_we_n));

  // R6: data bus enabled only while the read strobe is idle
  a_r6_oe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);

  // R8: requests are taken only from a ready device
  a_r8_accept_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> dev_ready);

  // R8: a freshly risen ready/busy line has not settled yet
  a_r8_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_sync) |-> !dev_ready);

  // R9: a held response keeps its byte
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9: nothing new is taken while a response waits
  a_r9_no_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10: strobes exclusive and only under chip enable
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));

  a_r10_strobe_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n || !nand_we_n) |-> !nand_ce_n);

endmodule

bind nand_strobe_timer nst_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_armed  (cfg_armed),
  .cfg_timing (cfg_timing),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .dev_ready  (dev_ready),
  .rb_sync    (rb_sync),
  .nand_ce_n  (nand_ce_n),
  .nand_re_n  (nand_re_n),
  .nand_we_n  (nand_we_n),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/sim_nand_strobe_timer.sv
module sim_nand_strobe_timer;

  localparam logic [25:0] BRST = {2'd1, 5'd2, 3'd1, 4'd2, 4'd2, 4'd2, 4'd2};

  // {cea, bsy, ta, rh, rl, wh, wl, write, byte}
  localparam logic [34:0] VEC [8] = '{
    {2'd1, 5'd1, 3'd2, 4'd2,  4'd3,  4'd1, 4'd2, 1'b0, 8'hA5},
    {2'd2, 5'd1, 3'd3, 4'd1,  4'd1,  4'd3, 4'd4, 1'b1, 8'h3C},
    {2'd0, 5'd1, 3'd5, 4'd0,  4'd0,  4'd2, 4'd1, 1'b0, 8'h5A},
    {2'd3, 5'd2, 3'd0, 4'd4,  4'd2,  4'd0, 4'd0, 1'b1, 8'h81},
    {2'd1, 5'd1, 3'd7, 4'd3,  4'd15, 4'd2, 4'd1, 1'b1, 8'h0F},
    {2'd1, 5'd1, 3'd0, 4'd1,  4'd2,  4'd1, 4'd1, 1'b0, 8'hF0},
    {2'd2, 5'd1, 3'd4, 4'd15, 4'd4,  4'd1, 4'd1, 1'b0, 8'h66},
    {2'd0, 5'd0, 3'd0, 4'd0,  4'd0,  4'd0, 4'd0, 1'b1, 8'h99}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_unlock = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [25:0] cfg_wdata = '0;
  logic [25:0] cfg_timing;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_rdata;
  logic        dev_ready;
  logic        nand_ce_n, nand_re_n, nand_we_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nand_strobe_timer #(.DW(8), .SYNC_STAGES(2), .RST_TIMING(BRST)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_unlock(cfg_unlock), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_timing(cfg_timing),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dev_ready(dev_ready),
    .nand_ce_n(nand_ce_n), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  function automatic int minc(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic program_word(input logic [25:0] w);
    @(negedge clk); cfg_unlock = 1'b1;
    @(negedge clk); cfg_unlock = 1'b0; cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_op(input bit wr, input logic [7:0] d, input int e_gap,
                       input int e_low, input int e_high, input int hold);
    int gap = 0, low = 0, high = 0, guard = 0;
    bit in_low = 1'b0, dq_bad = 1'b0, other_bad = 1'b0;
    @(negedge clk);
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!nand_ce_n && guard < 200) begin
      if ((wr ? nand_re_n : nand_we_n) == 1'b0) other_bad = 1'b1;
      if ((wr ? nand_we_n : nand_re_n) == 1'b0) begin
        low++; in_low = 1'b1;
        if (!wr) nand_dq_in = (low == e_low) ? d : ~d;
        else if (!(nand_dq_oe && nand_dq_out == d)) dq_bad = 1'b1;
      end else if (!in_low) begin
        gap++;
      end else begin
        high++;
        if (wr && !(nand_dq_oe && nand_dq_out == d)) dq_bad = 1'b1;
      end
      @(negedge clk); guard++;
    end
    nand_dq_in = '0;
    check(gap == e_gap, "R4/R7 access+turnaround gap", gap, e_gap);
    check(low == e_low, wr ? "R6 write low phase" : "R5 read low phase", low, e_low);
    check(high == e_high, wr ? "R6 write high phase" : "R5 read high phase", high, e_high);
    check(!other_bad, "R10 opposite strobe idle", other_bad, 0);
    if (wr) check(!dq_bad, "R6 data driven through cycle", dq_bad, 0);
    check(rsp_valid, "R9 response after high phase", rsp_valid, 1);
    check(rsp_rdata == (wr ? 8'h00 : d), "R5/R9 returned byte", rsp_rdata, wr ? 0 : d);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == (wr ? 8'h00 : d) && !req_ready,
            "R9 response held under back-pressure", rsp_valid, 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid, "R9 response released", rsp_valid, 0);
  endtask

  task automatic busy_window(input int settle);
    int n = 0;
    @(negedge clk); nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    check(!dev_ready, "R8 busy drops ready", dev_ready, 0);
    check(!req_ready, "R8 no request while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(nand_ce_n, "R8 request held off while busy", nand_ce_n, 1);
    end
    req_valid = 1'b0;
    nand_rb = 1'b1;
    do begin @(negedge clk); n++; end while (!dev_ready && n < 100);
    check(n == 2 + minc(settle), "R8 ready rise delay", n, 2 + minc(settle));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (run hung): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit prev_wr = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    check(nand_ce_n && nand_re_n && nand_we_n && !nand_dq_oe, "R10 reset strobes idle",
          {nand_ce_n, nand_re_n, nand_we_n, nand_dq_oe}, 4'b1110);
    check(!rsp_valid && !req_ready && !dev_ready, "R8/R9 reset handshake idle",
          {rsp_valid, req_ready, dev_ready}, 0);
    check(cfg_timing == BRST, "R2 reset timing word", cfg_timing, BRST);
    rst_n = 1'b1;
    while (!dev_ready) @(negedge clk);

    // R2: locked writes are ignored, one unlock permits one write
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 26'h155_5555;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
    check(cfg_timing == BRST, "R2 write without unlock ignored", cfg_timing, BRST);
    program_word(26'h0A1_2345);
    check(cfg_timing == 26'h0A1_2345, "R2 unlocked write applied", cfg_timing, 26'h0A1_2345);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 26'h3FF_FFFF;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
    check(cfg_timing == 26'h0A1_2345, "R2 second write relocked", cfg_timing, 26'h0A1_2345);

    // table of bus cycles
    for (int i = 0; i < 8; i++) begin
      logic [34:0] v;
      logic [25:0] w;
      bit wr;
      int e_gap, e_low, e_high;
      v  = VEC[i];
      w  = v[34:9];
      wr = v[8];
      program_word(w);
      check(cfg_timing == w, "R2 programmed word", cfg_timing, w);
      // R1 field positions, R3 zero counts as one, R7 gap rule
      e_gap  = minc(int'(w[25:24])) + ((!wr && prev_wr) ? minc(int'(w[18:16])) : 0);
      e_low  = minc(wr ? int'(w[3:0]) : int'(w[11:8]));
      e_high = minc(wr ? int'(w[7:4]) : int'(w[15:12]));
      do_op(wr, v[7:0], e_gap, e_low, e_high, i % 3);
      prev_wr = wr;
    end

    // R8 busy settle with a long and a zero count (R3)
    program_word({2'd1, 5'd5, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1});
    busy_window(5);
    program_word({2'd1, 5'd0, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1});
    busy_window(0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule